// File: doc/BRIEF.md
# Beam-Synchronised Memory Pattern Tester

This sequencer drives a pair of on-chip RAM macros through a radiation test timed by external beam equipment. After a start pulse it fills every word of both macros with a solid pattern, either all zeros or all ones. It then reads every word back to prove the array begins clean. Only a clean array lets it assert a hit request toward the beam controller. It then waits for that controller to confirm that an ion struck.

Once the hit is confirmed, the block sweeps the whole array twice. It emits one streaming record for each bit that no longer matches the pattern. A record carries the macro index, the word address and the bit position. Records leave through a valid/ready port, and back-pressure on that port freezes the sweep so that nothing is dropped. The hit wait can be bounded by a cycle limit. When the limit runs out the block abandons the run and raises a timeout flag. A dirty pre-hit sweep also ends the run, but it raises a separate fault flag instead.

Both macros are accessed together, one address per access, through a synchronous memory port with a single cycle of read latency. Macro 0 (the lower one) occupies the low `DATA_W` bits of the read bus.

Top module: `beam_mem_tester`

## Requirements
- R1: A start pulse accepted in idle causes one write sweep to both macros together. The sweep visits addresses 0 to DEPTH-1 in ascending order, one per cycle, and writes all ones when `pattern_ones` was 1 at start and all zeros otherwise.
- R2: After the write sweep, every address is read once and compared with the pattern. On the first mismatch the run ends: `pre_fault` is set, no further address is read, `hit_req` is never raised and no record is emitted.
- R3: After a clean check sweep, `hit_req` rises and stays high until `hit_ack` is seen. The memory port stays idle (`mem_cs` all zero) while it waits.
- R4: `hit_req` falls in the cycle after `hit_ack` is sampled high. Two complete read sweeps of every address then follow.
- R5: With `timeout_limit` = T > 0, an unanswered `hit_req` stays high for exactly T cycles. The block then returns to idle with `hit_timeout` set. With T = 0 it waits indefinitely.
- R6: Each bit that differs from the pattern in either post-hit sweep yields exactly one record (`err_macro`, `err_addr`, `err_bit`). The order is first sweep then second sweep, then ascending address, then ascending macro, then ascending bit.
- R7: While `err_valid` is high and `err_ready` is low, the record fields hold steady and the memory port stays idle. No record is lost or repeated.
- R8: `run_done` pulses for one cycle as the block returns to idle, and `busy` is high for the whole run. `pre_fault` and `hit_timeout` persist until the next accepted start, which clears them. A start pulse during a run has no effect.
- R9: After reset the block is idle: `busy`, `hit_req`, `err_valid`, `run_done`, `pre_fault`, `hit_timeout` and `mem_cs` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| pattern_ones | input | 1 | 1 selects the all-ones pattern, 0 all-zeros; latched at start |
| timeout_limit | input | TMO_W | Hit wait bound in cycles, 0 = unbounded; latched at start |
| mem_cs | output | N_MACRO | Per-macro select |
| mem_we | output | 1 | Write enable |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | N_MACRO*DATA_W | Read data, macro 0 in the low bits, one cycle after select |
| hit_req | output | 1 | Request for an ion hit |
| hit_ack | input | 1 | Beam side reports an ion detected |
| err_valid | output | 1 | Error record present |
| err_ready | input | 1 | Consumer accepts the record |
| err_macro | output | MACRO_W | Macro index of the wrong bit |
| err_addr | output | ADDR_W | Word address of the wrong bit |
| err_bit | output | BIT_W | Bit position within the word |
| busy | output | 1 | Run in progress |
| run_done | output | 1 | One-cycle end-of-run pulse |
| pre_fault | output | 1 | Pre-hit check found a mismatch |
| hit_timeout | output | 1 | Hit wait expired |

## Verification
The bench targets several corner cases, each paired with the failure it would expose.
- Words with several wrong bits in both macros at once. A serializer that skipped, repeated or reordered bits would emit a record stream that differs from the list the bench builds arithmetically.
- A consumer that stalls on a pattern of one cycle in three. A sweep that ran on during a stall would change the record fields mid-offer, lose records, or touch memory while a record waits.
- A mismatch at address 5 before the hit. The run must stop after exactly six check reads with no request; a late abort shows up in the read count.
- Timeout limits of 5 and 1. An off-by-one in the wait counter would change the number of cycles the request stays high.
- A long wait with no limit. A request that lapsed, or that reacted to a stray start pulse, would cut the run short.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_RD_ISSUE,
      ST_RD_CHECK,
      ST_EMIT,
      ST_HIT_WAIT
   } bmt_state_e;

   typedef enum logic [1:0] {
      PASS_CHECK,
      PASS_FIRST,
      PASS_SECOND
   } bmt_pass_e;

endpackage

// File: rtl/bmt_sweep_ctr.sv
module bmt_sweep_ctr #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   addr <= '0;
      else if (clr) addr <= '0;
      else if (inc) addr <= addr + ADDR_W'(1);
   end

   assign last = &addr;

endmodule

// File: rtl/bmt_hit_wait.sv
module bmt_hit_wait #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             waiting,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);

   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!waiting) cnt_q <= '0;
      else               cnt_q <= cnt_q + TMO_W'(1);
   end

   assign expired = waiting && (limit != '0) && (cnt_q == limit - TMO_W'(1));

endmodule

// File: rtl/bmt_err_serial.sv
module bmt_err_serial #(
   parameter int N_MACRO = 2,
   parameter int DATA_W  = 9,
   parameter int MACRO_W = 1,
   parameter int BIT_W   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [N_MACRO*DATA_W-1:0]   load_mask,
   input  logic                        pop,
   output logic                        valid,
   output logic                        last,
   output logic [MACRO_W-1:0]          macro,
   output logic [BIT_W-1:0]            bitpos
);

   localparam int NBITS = N_MACRO * DATA_W;

   logic [NBITS-1:0] mask_q;
   logic [NBITS-1:0] lowest;
   logic             found;

   assign lowest = mask_q & (~mask_q + NBITS'(1));
   assign valid  = |mask_q;
   assign last   = ((mask_q & (mask_q - NBITS'(1))) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              mask_q <= '0;
      else if (load)           mask_q <= load_mask;
      else if (pop && valid)   mask_q <= mask_q & ~lowest;
   end

   always_comb begin
      found  = 1'b0;
      macro  = '0;
      bitpos = '0;
      for (int m = 0; m < N_MACRO; m++) begin
         for (int b = 0; b < DATA_W; b++) begin
            if (!found && mask_q[m*DATA_W + b]) begin
               found  = 1'b1;
               macro  = MACRO_W'(m);
               bitpos = BIT_W'(b);
            end
         end
      end
   end

endmodule

// File: rtl/beam_mem_tester.sv
module beam_mem_tester
   import bmt_pkg::*;
#(
   parameter int ADDR_W  = 9,
   parameter int DATA_W  = 9,
   parameter int N_MACRO = 2,
   parameter int TMO_W   = 16,
   localparam int NBITS   = N_MACRO * DATA_W,
   localparam int MACRO_W = (N_MACRO > 1) ? $clog2(N_MACRO) : 1,
   localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pattern_ones,
   input  logic [TMO_W-1:0]   timeout_limit,
   output logic [N_MACRO-1:0] mem_cs,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [NBITS-1:0]   mem_rdata,
   output logic               hit_req,
   input  logic               hit_ack,
   output logic               err_valid,
   input  logic               err_ready,
   output logic [MACRO_W-1:0] err_macro,
   output logic [ADDR_W-1:0]  err_addr,
   output logic [BIT_W-1:0]   err_bit,
   output logic               busy,
   output logic               run_done,
   output logic               pre_fault,
   output logic               hit_timeout
);

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..20");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (N_MACRO < 1) begin : g_bad_macros
      $error("N_MACRO must be at least 1");
   end
   if (TMO_W < 1) begin : g_bad_tmo_w
      $error("TMO_W must be at least 1");
   end

   bmt_state_e        state_q, state_d;
   bmt_pass_e         pass_q, pass_d;
   logic              pat_q;
   logic [TMO_W-1:0]  limit_q;
   logic [NBITS-1:0]  pat_rep;
   logic [NBITS-1:0]  mism;
   logic [ADDR_W-1:0] addr;
   logic              addr_last;
   logic              ctr_clr, ctr_inc;
   logic              ser_load, ser_pop, ser_valid, ser_last;
   logic              tmo_expired;
   logic              word_done, finish, set_fault, set_tmo;
   logic              start_acc;

   for (genvar g = 0; g < N_MACRO; g++) begin : g_pat
      assign pat_rep[g*DATA_W +: DATA_W] = {DATA_W{pat_q}};
   end

   assign mism      = mem_rdata ^ pat_rep;
   assign start_acc = (state_q == ST_IDLE) && start;

   bmt_sweep_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clr),
      .inc   (ctr_inc),
      .addr  (addr),
      .last  (addr_last)
   );

   bmt_hit_wait #(.TMO_W(TMO_W)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (state_q == ST_HIT_WAIT),
      .limit   (limit_q),
      .expired (tmo_expired)
   );

   bmt_err_serial #(
      .N_MACRO (N_MACRO),
      .DATA_W  (DATA_W),
      .MACRO_W (MACRO_W),
      .BIT_W   (BIT_W)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ser_load),
      .load_mask (mism),
      .pop       (ser_pop),
      .valid     (ser_valid),
      .last      (ser_last),
      .macro     (err_macro),
      .bitpos    (err_bit)
   );

   always_comb begin
      state_d   = state_q;
      pass_d    = pass_q;
      ctr_clr   = 1'b0;
      ctr_inc   = 1'b0;
      ser_load  = 1'b0;
      ser_pop   = 1'b0;
      word_done = 1'b0;
      finish    = 1'b0;
      set_fault = 1'b0;
      set_tmo   = 1'b0;
      mem_cs    = '0;
      mem_we    = 1'b0;

      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = ST_WRITE;
               ctr_clr = 1'b1;
            end
         end
         ST_WRITE: begin
            mem_cs = '1;
            mem_we = 1'b1;
            if (addr_last) begin
               ctr_clr = 1'b1;
               pass_d  = PASS_CHECK;
               state_d = ST_RD_ISSUE;
            end else begin
               ctr_inc = 1'b1;
            end
         end
         ST_RD_ISSUE: begin
            mem_cs  = '1;
            state_d = ST_RD_CHECK;
         end
         ST_RD_CHECK: begin
            if (mism != '0) begin
               if (pass_q == PASS_CHECK) begin
                  set_fault = 1'b1;
                  finish    = 1'b1;
                  state_d   = ST_IDLE;
               end else begin
                  ser_load = 1'b1;
                  state_d  = ST_EMIT;
               end
            end else begin
               word_done = 1'b1;
            end
         end
         ST_EMIT: begin
            ser_pop = err_ready;
            if (err_ready && ser_last) word_done = 1'b1;
         end
         ST_HIT_WAIT: begin
            if (hit_ack) begin
               ctr_clr = 1'b1;
               pass_d  = PASS_FIRST;
               state_d = ST_RD_ISSUE;
            end else if (tmo_expired) begin
               set_tmo = 1'b1;
               finish  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase

      if (word_done) begin
         if (addr_last) begin
            ctr_clr = 1'b1;
            case (pass_q)
               PASS_CHECK: state_d = ST_HIT_WAIT;
               PASS_FIRST: begin
                  pass_d  = PASS_SECOND;
                  state_d = ST_RD_ISSUE;
               end
               default: begin
                  finish  = 1'b1;
                  state_d = ST_IDLE;
               end
            endcase
         end else begin
            ctr_inc = 1'b1;
            state_d = ST_RD_ISSUE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pass_q      <= PASS_CHECK;
         pat_q       <= 1'b0;
         limit_q     <= '0;
         run_done    <= 1'b0;
         pre_fault   <= 1'b0;
         hit_timeout <= 1'b0;
      end else begin
         state_q  <= state_d;
         pass_q   <= pass_d;
         run_done <= finish;
         if (start_acc) begin
            pat_q       <= pattern_ones;
            limit_q     <= timeout_limit;
            pre_fault   <= 1'b0;
            hit_timeout <= 1'b0;
         end
         if (set_fault) pre_fault   <= 1'b1;
         if (set_tmo)   hit_timeout <= 1'b1;
      end
   end

   assign mem_addr  = addr;
   assign mem_wdata = {DATA_W{pat_q}};
   assign hit_req   = (state_q == ST_HIT_WAIT);
   assign busy      = (state_q != ST_IDLE);
   assign err_valid = (state_q == ST_EMIT) && ser_valid;
   assign err_addr  = addr;

endmodule

// File: rtl/bmt_checker.sv
module bmt_checker #(
   parameter int ADDR_W  = 9,
   parameter int DATA_W  = 9,
   parameter int N_MACRO = 2,
   localparam int MACRO_W = (N_MACRO > 1) ? $clog2(N_MACRO) : 1,
   localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_MACRO-1:0] mem_cs,
   input logic               mem_we,
   input logic               hit_req,
   input logic               hit_ack,
   input logic               err_valid,
   input logic               err_ready,
   input logic [MACRO_W-1:0] err_macro,
   input logic [ADDR_W-1:0]  err_addr,
   input logic [BIT_W-1:0]   err_bit,
   input logic               busy,
   input logic               run_done,
   input logic               pre_fault,
   input logic               hit_timeout
);

   p_write_all_macros_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (&mem_cs));

   p_fault_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_fault |-> !hit_req);

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_req && !hit_ack) |=> (hit_req || hit_timeout));

   p_mem_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_req |-> (mem_cs == '0));

   p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_req && hit_ack) |=> !hit_req);

   p_bit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (int'(err_bit) < DATA_W));

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_ready) |=>
         (err_valid && $stable(err_macro) && $stable(err_addr) && $stable(err_bit)));

   p_stall_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (mem_cs == '0));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_done |=> !run_done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_done |-> !busy);

endmodule

bind beam_mem_tester bmt_checker #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .N_MACRO (N_MACRO)
) u_bmt_checker (.*);

// File: tb/beam_mem_tester_bench.sv
module beam_mem_tester_bench;

   localparam int AW    = 3;
   localparam int DW    = 4;
   localparam int NM    = 2;
   localparam int TW    = 8;
   localparam int DEPTH = 1 << AW;
   localparam int MW    = 1;
   localparam int BW    = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            pattern_ones = 1'b0;
   logic [TW-1:0]   timeout_limit = '0;
   logic [NM-1:0]   mem_cs;
   logic            mem_we;
   logic [AW-1:0]   mem_addr;
   logic [DW-1:0]   mem_wdata;
   logic [NM*DW-1:0] mem_rdata;
   logic            hit_req;
   logic            hit_ack = 1'b0;
   logic            err_valid;
   logic            err_ready;
   logic [MW-1:0]   err_macro;
   logic [AW-1:0]   err_addr;
   logic [BW-1:0]   err_bit;
   logic            busy, run_done, pre_fault, hit_timeout;

   beam_mem_tester #(.ADDR_W(AW), .DATA_W(DW), .N_MACRO(NM), .TMO_W(TW)) u_beam_mem_tester (
      .clk(clk), .rst_n(rst_n), .start(start), .pattern_ones(pattern_ones),
      .timeout_limit(timeout_limit), .mem_cs(mem_cs), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .hit_req(hit_req), .hit_ack(hit_ack), .err_valid(err_valid),
      .err_ready(err_ready), .err_macro(err_macro), .err_addr(err_addr),
      .err_bit(err_bit), .busy(busy), .run_done(run_done),
      .pre_fault(pre_fault), .hit_timeout(hit_timeout)
   );

   // memory model: stored words plus a read-side upset mask set by the test
   logic [DW-1:0] mem   [NM][DEPTH];
   logic [DW-1:0] upset [NM][DEPTH];
   logic [DW-1:0] rd    [NM];

   always @(posedge clk) begin
      for (int m = 0; m < NM; m++) begin
         if (mem_cs[m]) begin
            if (mem_we) mem[m][mem_addr] <= mem_wdata;
            else        rd[m] <= mem[m][mem_addr] ^ upset[m][mem_addr];
         end
      end
   end
   assign mem_rdata = {rd[1], rd[0]};

   // expected record list, filled by the test sequence
   int exp_m [256];
   int exp_a [256];
   int exp_b [256];
   int exp_n = 0;
   int rdy_mode = 0;
   logic exp_pat = 1'b0;

   // monitor state
   int cyc = 0, wr_n = 0, rd_n = 0, wr_bad = 0, got_n = 0, rec_bad = 0;
   int stall_bad = 0, wait_bad = 0, req_cyc = 0;
   logic prev_busy = 1'b0, prev_stall = 1'b0;
   logic [MW-1:0] pm;
   logic [AW-1:0] pa;
   logic [BW-1:0] pb;

   always @(negedge clk) begin
      cyc++;
      err_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (busy && !prev_busy) begin
         wr_n = 0; rd_n = 0; wr_bad = 0; got_n = 0; rec_bad = 0;
         stall_bad = 0; wait_bad = 0; req_cyc = 0;
      end
      prev_busy = busy;
      if (mem_cs != '0 && mem_we) begin
         if (mem_addr != AW'(wr_n) || mem_wdata != {DW{exp_pat}} || mem_cs != '1) wr_bad++;
         wr_n++;
      end
      if (mem_cs != '0 && !mem_we) rd_n++;
      if (hit_req) begin
         req_cyc++;
         if (mem_cs != '0) wait_bad++;
      end
      if (prev_stall && (!err_valid || err_macro != pm || err_addr != pa || err_bit != pb))
         stall_bad++;
      if (err_valid && mem_cs != '0) stall_bad++;
      prev_stall = err_valid && !err_ready;
      pm = err_macro; pa = err_addr; pb = err_bit;
      if (err_valid && err_ready) begin
         if (got_n >= exp_n) begin
            rec_bad++;
            $display("FAIL R6 extra record actual=%0d/%0d/%0d expected=none",
                     err_macro, err_addr, err_bit);
         end else if (int'(err_macro) != exp_m[got_n] || int'(err_addr) != exp_a[got_n] ||
                      int'(err_bit) != exp_b[got_n]) begin
            rec_bad++;
            $display("FAIL R6 record %0d actual=%0d/%0d/%0d expected=%0d/%0d/%0d", got_n,
                     err_macro, err_addr, err_bit, exp_m[got_n], exp_a[got_n], exp_b[got_n]);
         end
         got_n++;
      end
   end

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic clear_upsets();
      for (int m = 0; m < NM; m++)
         for (int a = 0; a < DEPTH; a++) upset[m][a] = '0;
      exp_n = 0;
   endtask

   task automatic build_expect();
      exp_n = 0;
      for (int p = 0; p < 2; p++)
         for (int a = 0; a < DEPTH; a++)
            for (int m = 0; m < NM; m++)
               for (int b = 0; b < DW; b++)
                  if (upset[m][a][b]) begin
                     exp_m[exp_n] = m; exp_a[exp_n] = a; exp_b[exp_n] = b;
                     exp_n++;
                  end
   endtask

   task automatic kick(input logic pat, input int lim);
      @(negedge clk);
      exp_pat = pat;
      pattern_ones = pat;
      timeout_limit = TW'(lim);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_req();
      while (!hit_req) @(negedge clk);
   endtask

   task automatic wait_done();
      while (!run_done) @(negedge clk);
   endtask

   task automatic ack();
      hit_ack = 1'b1;
      @(negedge clk);
      hit_ack = 1'b0;
      chk(!hit_req, "R4", "hit_req after ack", hit_req, 0);
   endtask

   task automatic fault_run(input logic pat, input int mode);
      kick(pat, 0);
      wait_req();
      chk(wr_n == DEPTH && wr_bad == 0, "R1", "write sweep", wr_n, DEPTH);
      if (mode == 0) begin
         for (int m = 0; m < NM; m++)
            for (int a = 0; a < DEPTH; a++)
               upset[m][a] = ((a + m) % 3 == 2) ? '0 : DW'((a * 5 + m * 3 + 1) % 16);
      end else begin
         for (int m = 0; m < NM; m++)
            for (int a = 0; a < DEPTH; a++) upset[m][a] = '1;
      end
      build_expect();
      @(negedge clk);
      ack();
      wait_done();
      chk(got_n == exp_n, "R6", "record count", got_n, exp_n);
      chk(rec_bad == 0, "R6", "record mismatches", rec_bad, 0);
      chk(stall_bad == 0, "R7", "stall violations", stall_bad, 0);
      chk(rd_n == 3 * DEPTH, "R4", "read accesses", rd_n, 3 * DEPTH);
      clear_upsets();
   endtask

   task automatic run_all();
      clear_upsets();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(!busy && !hit_req && !err_valid && !run_done, "R9", "idle outputs", busy, 0);
      chk(!pre_fault && !hit_timeout, "R9", "flags after reset", pre_fault, 0);
      chk(mem_cs == '0, "R9", "mem_cs after reset", mem_cs, 0);

      // clean run, zeros pattern, unbounded wait with stray start
      kick(1'b0, 0);
      chk(busy, "R8", "busy during run", busy, 1);
      wait_req();
      chk(wr_n == DEPTH && wr_bad == 0, "R1", "zeros write sweep", wr_n, DEPTH);
      chk(rd_n == DEPTH, "R2", "check reads", rd_n, DEPTH);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (300) @(negedge clk);
      chk(hit_req && !hit_timeout, "R5", "unbounded wait still requesting", hit_req, 1);
      chk(wait_bad == 0, "R3", "memory access during wait", wait_bad, 0);
      ack();
      wait_done();
      chk(rd_n == 3 * DEPTH, "R4", "reads after hit", rd_n, 3 * DEPTH);
      chk(got_n == 0, "R6", "records on clean array", got_n, 0);
      chk(!pre_fault && !hit_timeout, "R8", "flags after clean run", pre_fault, 0);
      @(negedge clk);
      chk(!run_done && !busy, "R8", "done is one cycle", run_done, 0);
      for (int m = 0; m < NM; m++)
         for (int a = 0; a < DEPTH; a++)
            chk(mem[m][a] == '0, "R1", "stored zero word", mem[m][a], 0);

      // multi-bit upsets, ones pattern, stalling consumer
      rdy_mode = 1;
      fault_run(1'b1, 0);
      for (int m = 0; m < NM; m++)
         for (int a = 0; a < DEPTH; a++)
            chk(mem[m][a] == '1, "R1", "stored ones word", mem[m][a], 15);
      // every bit upset, zeros pattern, always ready
      rdy_mode = 0;
      fault_run(1'b0, 1);

      // mismatch before the hit
      upset[1][5] = 4'b0010;
      kick(1'b0, 0);
      wait_done();
      chk(pre_fault, "R2", "pre_fault set", pre_fault, 1);
      chk(req_cyc == 0, "R2", "request cycles on fault", req_cyc, 0);
      chk(rd_n == 6, "R2", "check reads before abort", rd_n, 6);
      chk(got_n == 0, "R2", "records on fault", got_n, 0);
      clear_upsets();

      // bounded waits
      kick(1'b1, 5);
      wait_done();
      chk(!pre_fault, "R8", "pre_fault cleared by start", pre_fault, 0);
      chk(hit_timeout, "R5", "timeout flag", hit_timeout, 1);
      chk(req_cyc == 5, "R5", "request cycles limit 5", req_cyc, 5);
      chk(rd_n == DEPTH, "R5", "no reads after timeout", rd_n, DEPTH);
      kick(1'b0, 1);
      wait_done();
      chk(req_cyc == 1, "R5", "request cycles limit 1", req_cyc, 1);
      @(negedge clk);
      chk(!hit_req && !busy && hit_timeout, "R5", "idle after timeout", hit_req, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(negedge clk);
            chk(1'b0, "WD", "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule